// File: doc/BRIEF.md
# Configurable Base Address Register Bank with Zero-Base Disable

This block holds the base address registers of a bus target and decides, for each incoming access, which of them it falls into. Each register slot has a fixed kind and a fixed power-of-two window size, both chosen by parameter. A configuration port writes and reads the slots by index. A write lands only on the programmable base bits. Writing all ones and reading back therefore gives the size mask, which is how software probes the window size.

A base of zero switches a slot off, unless the slot's encoding says that zero is a legal base. An I/O slot carries a writable flag in bit 1. When the flag is set, zero becomes a valid base for that slot. A 32-bit memory slot with type code 11 always decodes, even at zero, and so acts as a mandatory window. A 32-bit memory slot with type code 00 is optional and can be disabled by writing zero to it. A 64-bit memory slot uses two consecutive indices. It is enabled only while its upper word is nonzero. A constant output tells software that the block supports this optional-window convention.

The hit vector is registered. It reports the access that was presented at the previous clock edge, decoded against the register contents that held before that edge.

Top module: `bar_bank`

## Requirements
- R1: After reset every stored base and every I/O zero-valid flag is zero. Each slot then reads back only its fixed encoding bits, and no slot except a type-11 memory slot can produce a hit.
- R2: A configuration write stores the written data only in bits at or above the slot's size boundary. The exception is the upper word of a 64-bit slot, which stores all 32 bits. Writing all ones therefore reads back ones above the boundary and zeros below it, apart from the fixed bits.
- R3: The fixed bits cannot be written. An I/O slot reads bit 0 as 1. A memory slot reads bit 0 as 0, bit 3 as 0 and bits 2:1 as its type: 00 for an optional 32-bit slot, 11 for a zero-valid 32-bit slot, 10 for the lower word of a 64-bit slot. An index with no register, or one beyond the last slot, reads 0 and ignores writes.
- R4: An I/O slot hits on an I/O access (`acc_io`=1) when address bits 31 down to its size boundary equal its base. The slot is enabled when its base is nonzero or its bit-1 flag is set. With a zero base and the flag clear, it never hits.
- R5: A type-00 memory slot hits on a memory access with address bits 63:32 all zero and the bits above its size boundary equal to its base. A base of zero disables it.
- R6: A type-11 memory slot decodes at whatever base it holds, including zero.
- R7: A 64-bit slot compares all 64 address bits above its size boundary. An upper word of zero disables it, whatever the lower word holds. As a result, an address with bits 63:32 all zero never hits it. The hit bit of the upper-word index, and of any index with no register, is never set.
- R8: An I/O access never hits a memory slot, and a memory access never hits an I/O slot.
- R9: The hit output appears one clock after the access is presented. It is decoded against the register contents before any configuration write made at that same edge.
- R10: `zero_dis_cap` is always 1, advertising support for the zero-base disable convention.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (3) | Slot index for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the indexed slot (combinational) |
| acc_addr | input | 64 | Access address to decode |
| acc_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| hit | output | NUM_SLOTS (6) | Registered per-slot hit vector |
| zero_dis_cap | output | 1 | Capability flag for the zero-base disable convention |

## Verification
The assertions run on every cycle. They check that the fixed encoding bits and the zeros below each size boundary hold in every readback. They check that the access space separates I/O hits from memory hits. They also check that a 64-bit slot never answers an address whose upper word is zero, and that the upper-word and empty indices never hit. Whether a given base actually decodes depends on what has been programmed: enable under a zero base, the zero-valid flag, the mandatory type-11 window, and an upper word switching a 64-bit slot on or off. Only the bench's write-then-access scenarios can show that, comparing the hit vector against a model of the stored registers.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

    typedef logic [2:0] slot_kind_t;

    localparam slot_kind_t KIND_NONE    = 3'd0;
    localparam slot_kind_t KIND_IO      = 3'd1;
    localparam slot_kind_t KIND_MEM32   = 3'd2;
    localparam slot_kind_t KIND_MEM32Z  = 3'd3;
    localparam slot_kind_t KIND_MEM64LO = 3'd4;
    localparam slot_kind_t KIND_MEM64HI = 3'd5;

    // Memory type codes that sit in readback bits 2:1
    localparam logic [1:0] MTYPE_32  = 2'b00;
    localparam logic [1:0] MTYPE_64  = 2'b10;
    localparam logic [1:0] MTYPE_32Z = 2'b11;

    typedef struct packed {
        logic [31:0] val;
        logic        zflag;
    } slot_state_t;

    function automatic logic [31:0] fixed_bits(input slot_kind_t k, input logic zflag);
        logic [31:0] f;
        f = '0;
        case (k)
            KIND_IO:      f = {30'b0, zflag, 1'b1};
            KIND_MEM32:   f = {28'b0, 1'b0, MTYPE_32, 1'b0};
            KIND_MEM32Z:  f = {28'b0, 1'b0, MTYPE_32Z, 1'b0};
            KIND_MEM64LO: f = {28'b0, 1'b0, MTYPE_64, 1'b0};
            default:      f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/bar_bank_reg.sv
module bar_bank_reg
    import bar_bank_pkg::*;
#(
    parameter slot_kind_t  KIND      = KIND_NONE,
    parameter int unsigned SIZE_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] val,
    output logic        zflag,
    output logic [31:0] rdata
);
    localparam logic [31:0] SZ_MASK = 32'hFFFF_FFFF << SIZE_LOG2;
    localparam logic [31:0] WMASK   = (KIND == KIND_MEM64HI) ? 32'hFFFF_FFFF :
                                      (KIND == KIND_NONE)    ? 32'h0 : SZ_MASK;
    localparam logic        FLAG_WR = (KIND == KIND_IO);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val   = wdata & WMASK;
            st_d.zflag = FLAG_WR ? wdata[1] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val   = st_q.val;
    assign zflag = st_q.zflag;

    always_comb begin
        if (KIND == KIND_NONE) rdata = '0;
        else                   rdata = st_q.val | fixed_bits(KIND, st_q.zflag);
    end

endmodule

// File: rtl/bar_bank_dec.sv
module bar_bank_dec
    import bar_bank_pkg::*;
#(
    parameter slot_kind_t  KIND      = KIND_NONE,
    parameter int unsigned SIZE_LOG2 = 4
) (
    input  logic [31:0] lo_val,
    input  logic [31:0] hi_val,
    input  logic        zflag,
    input  logic [63:0] addr,
    input  logic        acc_io,
    output logic        match
);
    localparam logic [31:0] CMASK = 32'hFFFF_FFFF << SIZE_LOG2;

    logic lo_eq;
    logic up_zero;

    assign lo_eq   = ((addr[31:0] & CMASK) == lo_val);
    assign up_zero = (addr[63:32] == 32'h0);

    always_comb begin
        case (KIND)
            KIND_IO:      match = acc_io & ((lo_val != 32'h0) | zflag) & lo_eq;
            KIND_MEM32:   match = !acc_io & (lo_val != 32'h0) & up_zero & lo_eq;
            KIND_MEM32Z:  match = !acc_io & up_zero & lo_eq;
            KIND_MEM64LO: match = !acc_io & (hi_val != 32'h0) &
                                  (addr[63:32] == hi_val) & lo_eq;
            default:      match = 1'b0;
        endcase
    end

endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_bank_pkg::*;
#(
    parameter int unsigned                    NUM_SLOTS = 6,
    parameter logic [NUM_SLOTS-1:0][2:0]      SLOT_KIND = {3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1},
    parameter logic [NUM_SLOTS-1:0][5:0]      SLOT_SIZE = {6'd0, 6'd0, 6'd20, 6'd16, 6'd12, 6'd5},
    localparam int unsigned                   IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [63:0]          acc_addr,
    input  logic                 acc_io,
    output logic [NUM_SLOTS-1:0] hit,
    output logic                 zero_dis_cap
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] hit;
    } bank_state_t;

    logic [NUM_SLOTS-1:0][31:0] slot_val;
    logic [NUM_SLOTS-1:0][31:0] slot_hi;
    logic [NUM_SLOTS-1:0][31:0] slot_rd;
    logic [NUM_SLOTS-1:0]       slot_zf;
    logic [NUM_SLOTS-1:0]       slot_match;

    bank_state_t st_d, st_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        bar_bank_reg #(
            .KIND      (slot_kind_t'(SLOT_KIND[i])),
            .SIZE_LOG2 (int'(SLOT_SIZE[i]))
        ) reg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cfg_wr && (cfg_idx == IDX_W'(i))),
            .wdata (cfg_wdata),
            .val   (slot_val[i]),
            .zflag (slot_zf[i]),
            .rdata (slot_rd[i])
        );

        if (i + 1 < NUM_SLOTS) begin : g_hi
            assign slot_hi[i] = slot_val[i+1];
        end else begin : g_nohi
            assign slot_hi[i] = '0;
        end

        bar_bank_dec #(
            .KIND      (slot_kind_t'(SLOT_KIND[i])),
            .SIZE_LOG2 (int'(SLOT_SIZE[i]))
        ) dec_i (
            .lo_val (slot_val[i]),
            .hi_val (slot_hi[i]),
            .zflag  (slot_zf[i]),
            .addr   (acc_addr),
            .acc_io (acc_io),
            .match  (slot_match[i])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (cfg_idx == IDX_W'(i)) cfg_rdata = slot_rd[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = slot_match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit          = st_q.hit;
    assign zero_dis_cap = 1'b1;

endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk
    import bar_bank_pkg::*;
#(
    parameter int unsigned               NUM_SLOTS = 6,
    parameter logic [NUM_SLOTS-1:0][2:0] SLOT_KIND = {3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1},
    parameter logic [NUM_SLOTS-1:0][5:0] SLOT_SIZE = {6'd0, 6'd0, 6'd20, 6'd16, 6'd12, 6'd5},
    localparam int unsigned              IDX_W     = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IDX_W-1:0]     cfg_idx,
    input logic [31:0]          cfg_rdata,
    input logic [63:0]          acc_addr,
    input logic                 acc_io,
    input logic [NUM_SLOTS-1:0] hit
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        localparam slot_kind_t  K    = slot_kind_t'(SLOT_KIND[i]);
        localparam logic [31:0] LOWZ = ~(32'hFFFF_FFFF << SLOT_SIZE[i]);

        if (K == KIND_IO) begin : g_io
            AST_IO_SPACE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                !acc_io |=> !hit[i]); // R8
            AST_IO_FIXED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_idx == IDX_W'(i)) |-> (cfg_rdata[0] == 1'b1)); // R3
            AST_IO_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_idx == IDX_W'(i)) |-> ((cfg_rdata & LOWZ & ~32'h3) == 32'h0)); // R2
        end else if (K == KIND_MEM32 || K == KIND_MEM32Z || K == KIND_MEM64LO) begin : g_mem
            localparam logic [1:0] TY = (K == KIND_MEM32)  ? MTYPE_32 :
                                        (K == KIND_MEM32Z) ? MTYPE_32Z : MTYPE_64;
            AST_MEM_SPACE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                acc_io |=> !hit[i]); // R8
            AST_MEM_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_idx == IDX_W'(i)) |-> (cfg_rdata[3:0] == {1'b0, TY, 1'b0})); // R3
            AST_MEM_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_idx == IDX_W'(i)) |-> ((cfg_rdata & LOWZ & ~32'hF) == 32'h0)); // R2
            if (K == KIND_MEM64LO) begin : g_m64
                AST_M64_NO_LOW4G: assert property (@(posedge clk) disable iff (!rst_n)
                    (!acc_io && (acc_addr[63:32] == 32'h0)) |=> !hit[i]); // R7
            end
        end else begin : g_silent
            AST_NO_HIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
                !hit[i]); // R7
        end
    end
endmodule

bind bar_bank bar_bank_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_KIND (SLOT_KIND),
    .SLOT_SIZE (SLOT_SIZE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_idx   (cfg_idx),
    .cfg_rdata (cfg_rdata),
    .acc_addr  (acc_addr),
    .acc_io    (acc_io),
    .hit       (hit)
);

// File: tb/bar_bank_tb_top.sv
`timescale 1ns/1ps
module bar_bank_tb_top;
    localparam int NS = 6;
    localparam int KIND [NS] = '{1, 2, 3, 4, 5, 0};
    localparam int SZ   [NS] = '{5, 12, 16, 20, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] acc_addr = '0;
    logic        acc_io = 1'b0;
    logic [5:0]  hit;
    logic        zero_dis_cap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_val [NS];
    logic        m_zf  [NS];

    always #2.5 clk = ~clk;

    bar_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_io(acc_io), .hit(hit), .zero_dis_cap(zero_dis_cap)
    );

    function automatic logic [31:0] wmask(input int i);
        if (KIND[i] == 5) return 32'hFFFF_FFFF;
        if (KIND[i] == 0) return 32'h0;
        return 32'hFFFF_FFFF << SZ[i];
    endfunction

    function automatic logic [31:0] exp_rd(input int i);
        if (i >= NS) return 32'h0;
        case (KIND[i])
            1: return m_val[i] | {30'b0, m_zf[i], 1'b1};
            2: return m_val[i];
            3: return m_val[i] | 32'h6;
            4: return m_val[i] | 32'h4;
            5: return m_val[i];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [5:0] exp_hit(input logic [63:0] a, input logic io);
        logic [5:0] e;
        e = '0;
        for (int i = 0; i < NS; i++) begin
            logic lo;
            lo = ((a[31:0] & wmask(i)) == m_val[i]);
            case (KIND[i])
                1: e[i] = io && (m_val[i] != 0 || m_zf[i]) && lo;
                2: e[i] = !io && a[63:32] == 0 && m_val[i] != 0 && lo;
                3: e[i] = !io && a[63:32] == 0 && lo;
                4: e[i] = !io && m_val[i+1] != 0 && a[63:32] == m_val[i+1] && lo;
                default: e[i] = 1'b0;
            endcase
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic wr, input int idx, input logic [31:0] wd,
                        input logic [63:0] a, input logic io, input string tag);
        logic [5:0] e;
        cfg_wr = wr; cfg_idx = idx[2:0]; cfg_wdata = wd; acc_addr = a; acc_io = io;
        e = exp_hit(a, io);
        @(posedge clk);
        if (wr && idx < NS) begin
            m_val[idx] = wd & wmask(idx);
            if (KIND[idx] == 1) m_zf[idx] = wd[1];
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(tag, {58'b0, hit}, {58'b0, e}, "hit");
    endtask

    task automatic rd(input int idx, input string tag);
        cfg_idx = idx[2:0];
        #1;
        chk(tag, {32'b0, cfg_rdata}, {32'b0, exp_rd(idx)}, "rdata");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < NS; i++) begin m_val[i] = '0; m_zf[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R3: reset readback and idle decode
        for (int i = 0; i < 8; i++) rd(i, "R1");
        step(0, 0, 0, 64'h0, 1'b1, "R1");
        step(0, 0, 0, 64'h0, 1'b0, "R1");
        chk("R10", {63'b0, zero_dis_cap}, 64'h1, "cap");

        // R2: size probe on each slot, R3 for empty indices
        for (int i = 0; i < 8; i++) begin
            step(1, i, 32'hFFFF_FFFF, 64'h1234, 1'b0, "R9");
            rd(i, (i >= 5) ? "R3" : "R2");
            step(1, i, 32'h0, 64'h0, 1'b1, "R9");
            rd(i, "R3");
        end

        // R4: I/O zero-valid flag
        step(0, 0, 0, 64'h10, 1'b1, "R4");
        step(1, 0, 32'h2, 64'h10, 1'b1, "R9");
        step(0, 0, 0, 64'h10, 1'b1, "R4");
        step(0, 0, 0, 64'h10, 1'b0, "R8");
        step(1, 0, 32'h0, 64'h0, 1'b1, "R4");
        step(0, 0, 0, 64'h0, 1'b1, "R4");
        step(1, 0, 32'h0000_C3A0, 64'h0, 1'b0, "R4");
        step(0, 0, 0, 64'h0000_C3BF, 1'b1, "R4");
        step(0, 0, 0, 64'h0000_C3C0, 1'b1, "R4");

        // R5: optional 32-bit memory
        step(0, 0, 0, 64'h0000_0000_0000_0800, 1'b0, "R5");
        step(1, 1, 32'h0000_3000, 64'h0, 1'b0, "R5");
        step(0, 0, 0, 64'h0000_0000_0000_3ABC, 1'b0, "R5");
        step(0, 0, 0, 64'h0000_0001_0000_3ABC, 1'b0, "R5");
        step(0, 0, 0, 64'h0000_0000_0000_3ABC, 1'b1, "R8");

        // R6: mandatory window at zero
        step(0, 0, 0, 64'h0000_0000_0000_FFFF, 1'b0, "R6");
        step(0, 0, 0, 64'h0000_0000_0001_0000, 1'b0, "R6");

        // R7: 64-bit slot
        step(1, 3, 32'h0010_0000, 64'h0, 1'b0, "R7");
        step(0, 0, 0, 64'h0000_0000_0010_0040, 1'b0, "R7");
        step(1, 4, 32'h1, 64'h0, 1'b0, "R7");
        step(0, 0, 0, 64'h0000_0001_0010_0040, 1'b0, "R7");
        step(0, 0, 0, 64'h0000_0000_0010_0040, 1'b0, "R7");
        step(0, 0, 0, 64'h0000_0002_0010_0040, 1'b0, "R7");

        // R9: write and access in the same cycle see the old contents
        step(1, 4, 32'h0, 64'h0000_0001_0010_0000, 1'b0, "R9");
        step(0, 0, 0, 64'h0000_0001_0010_0000, 1'b0, "R9");

        // Random mix
        for (int n = 0; n < 800; n++) begin
            logic        wr;
            int          idx;
            logic [31:0] wd;
            logic [63:0] a;
            logic        io;
            int          j;
            wr  = ($urandom % 10) < 3;
            idx = $urandom % 8;
            case ($urandom % 4)
                0: wd = 32'h0;
                1: wd = 32'hFFFF_FFFF;
                2: wd = $urandom % 4;
                default: wd = $urandom;
            endcase
            j = $urandom % 5;
            if (j < 4) begin
                a = {32'h0, (m_val[j] & wmask(j)) | ($urandom & ~wmask(j))};
                if (j == 3) a[63:32] = m_val[4];
                io = (j == 0) ? (($urandom % 5) != 0) : (($urandom % 5) == 0);
            end else begin
                a = {(($urandom % 2) == 0) ? 32'h0 : 32'($urandom % 3), 32'($urandom)};
                io = $urandom % 2;
            end
            step(wr, idx, wd, a, io, "R9");
            rd($urandom % 8, "R2");
        end

        chk("R10", {63'b0, zero_dis_cap}, 64'h1, "cap");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule